// File: doc/BRIEF.md
# Burst Address Sequencer

This block drives the address lines of a synchronous burst memory array. On a rising clock edge where an address strobe is accepted and the device is selected, it captures a full start address. It then presents that address as the first beat of a four-beat burst. Each later beat is produced inside the block by stepping a 2-bit position counter, one step per edge on which the advance input is high. The upper address bits never change during a burst.

There are two strobes. The processor strobe counts only while the primary chip enable is high. The controller strobe is always accepted. An accepted strobe loads a new burst when all three chip enables are high. If any chip enable is low, the accepted strobe ends the current burst instead. The burst order is sampled at load time: interleaved when the mode input is high, linear when it is low. The first beat is ready one edge after the strobe, and each later beat one edge after its advance, which gives a 2-1-1-1 pattern.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous active-high reset, `rst`, drives `burst_active` to 0 and `mem_addr` to all zeros on the next edge.
- R2: On an edge where `ads_ctrl` is 1 and `ce_pri`, `ce_aux1` and `ce_aux2` are all 1, the block loads `addr_in`. After that edge `mem_addr` equals the loaded address and `burst_active` is 1.
- R3: On an edge where `ads_proc` is 1 and all chip enables are 1, the block loads `addr_in` as in R2. When `ce_pri` is 0, `ads_proc` is ignored: with no other strobe and no advance, `mem_addr` and `burst_active` keep their values.
- R4: An accepted strobe (`ads_ctrl`=1, or `ads_proc`=1 with `ce_pri`=1) on an edge where any chip enable is 0 clears `burst_active` and leaves `mem_addr` unchanged.
- R5: The burst position moves forward by one only on an edge with `adv`=1, no accepted strobe, and `burst_active`=1. On any edge with no strobe and `adv`=0, `mem_addr` and `burst_active` hold their values.
- R6: With `mode`=1 at load time (interleaved), the low two bits of beat k are the start low bits XOR k.
- R7: With `mode`=0 at load time (linear), the low two bits of beat k are the start low bits plus k, modulo 4.
- R8: `mem_addr[AW-1:2]` does not change on any edge without an accepted strobe.
- R9: An accepted strobe with all chip enables high takes priority over `adv`. It restarts the burst at the new `addr_in`.
- R10: The burst position wraps: after beat 3, the next advance returns `mem_addr` to the start address and `burst_active` stays 1.
- R11: The burst order is fixed at load. Changing `mode` mid-burst has no effect on the order of the remaining beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ads_proc | input | 1 | Processor address strobe, active high, gated by ce_pri |
| ads_ctrl | input | 1 | Controller address strobe, active high |
| ce_pri | input | 1 | Primary chip enable, active high |
| ce_aux1 | input | 1 | First expansion chip enable, active high |
| ce_aux2 | input | 1 | Second expansion chip enable, active high |
| adv | input | 1 | Advance to the next beat, active high |
| mode | input | 1 | Burst order at load: 1 interleaved, 0 linear |
| addr_in | input | AW | Start address presented with a strobe |
| mem_addr | output | AW | Current array address |
| burst_active | output | 1 | A selected burst is in progress |

## Verification
The in-module assertions check on every cycle that reset clears the block and that a selected strobe loads the presented address, including when advance is also high. They also check that a gated processor strobe or an idle cycle leaves the state untouched, that a deselecting strobe ends the burst without moving the address, and that the upper bits stay fixed between strobes. Only the bench scenarios can show the exact beat sequences in interleaved and linear order from each start offset. They also show the wrap after the fourth beat and that a mid-burst change of `mode` has no effect. The bench's behavioural model checks these against `mem_addr` on every clock.

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int AW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ads_proc,
  input  logic          ads_ctrl,
  input  logic          ce_pri,
  input  logic          ce_aux1,
  input  logic          ce_aux2,
  input  logic          adv,
  input  logic          mode,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] mem_addr,
  output logic          burst_active
);

  localparam int UW = AW - 2;

  logic [AW-1:0] base_q;
  logic [1:0]    pos_q;
  logic          ilv_q;
  logic          act_q;

  wire strobe_ok = ads_ctrl | (ads_proc & ce_pri);
  wire selected  = ce_pri & ce_aux1 & ce_aux2;
  wire do_load   = strobe_ok & selected;
  wire do_drop   = strobe_ok & ~selected;
  wire do_step   = ~strobe_ok & adv & act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      pos_q  <= 2'd0;
      ilv_q  <= 1'b0;
      act_q  <= 1'b0;
    end else if (do_load) begin
      base_q <= addr_in;
      pos_q  <= 2'd0;
      ilv_q  <= mode;
      act_q  <= 1'b1;
    end else if (do_drop) begin
      act_q  <= 1'b0;
    end else if (do_step) begin
      pos_q  <= pos_q + 2'd1;
    end
  end

  wire [1:0] low_bits = ilv_q ? (base_q[1:0] ^ pos_q) : (base_q[1:0] + pos_q);

  assign mem_addr     = {base_q[AW-1:2], low_bits};
  assign burst_active = act_q;

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!burst_active && mem_addr == '0));

  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    do_load |=> (burst_active && mem_addr == $past(addr_in)));

  assert_proc_gated_R3: assert property (@(posedge clk) disable iff (rst)
    (ads_proc && !ce_pri && !ads_ctrl && !adv) |=> ($stable(mem_addr) && $stable(burst_active)));

  assert_deselect_R4: assert property (@(posedge clk) disable iff (rst)
    do_drop |=> (!burst_active && $stable(mem_addr)));

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!strobe_ok && !adv) |=> ($stable(mem_addr) && $stable(burst_active)));

  assert_upper_fixed_R8: assert property (@(posedge clk) disable iff (rst)
    !strobe_ok |=> $stable(mem_addr[AW-1:2]));

  assert_restart_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (do_load && adv) |=> (mem_addr == $past(addr_in)));

  initial assert (UW >= 1) else $error("AW too small");

endmodule

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;
  localparam int AW = 18;

  logic clk = 1'b0;
  logic rst, ads_proc, ads_ctrl, ce_pri, ce_aux1, ce_aux2, adv, mode;
  logic [AW-1:0] addr_in;
  logic [AW-1:0] mem_addr;
  logic burst_active;

  int checks = 0;
  int failures = 0;

  int m_base = 0, m_k = 0, m_mode = 0, m_act = 0;

  always #2 clk = ~clk;

  burst_addr_seq #(.AW(AW)) uut (
    .clk(clk), .rst(rst), .ads_proc(ads_proc), .ads_ctrl(ads_ctrl),
    .ce_pri(ce_pri), .ce_aux1(ce_aux1), .ce_aux2(ce_aux2), .adv(adv),
    .mode(mode), .addr_in(addr_in), .mem_addr(mem_addr), .burst_active(burst_active)
  );

  function automatic int model_addr();
    int lo;
    int b = m_base % 4;
    if (m_mode != 0) lo = b ^ m_k;
    else lo = (b + m_k) % 4;
    return (m_base - b) + lo;
  endfunction

  task automatic idle_inputs();
    rst = 0; ads_proc = 0; ads_ctrl = 0; adv = 0;
    ce_pri = 1; ce_aux1 = 1; ce_aux2 = 1;
  endtask

  task automatic tick(input string tag);
    int exp_a;
    @(posedge clk);
    if (rst) begin
      m_act = 0; m_base = 0; m_k = 0; m_mode = 0;
    end else if (ads_ctrl || (ads_proc && ce_pri)) begin
      if (ce_pri && ce_aux1 && ce_aux2) begin
        m_base = int'(addr_in); m_k = 0; m_mode = int'(mode); m_act = 1;
      end else m_act = 0;
    end else if (adv && m_act != 0) begin
      m_k = (m_k + 1) % 4;
    end
    @(negedge clk);
    exp_a = model_addr();
    checks++;
    if (int'(mem_addr) != exp_a || int'(burst_active) != m_act) begin
      failures++;
      $display("FAIL %s: addr=%h act=%0d expected addr=%h act=%0d",
               tag, mem_addr, burst_active, exp_a, m_act);
    end
  endtask

  task automatic expect_addr(input string tag, input int exp_a);
    checks++;
    if (int'(mem_addr) != exp_a) begin
      failures++;
      $display("FAIL %s: addr=%h expected %h", tag, mem_addr, exp_a);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle_inputs(); mode = 0; addr_in = '0;
    rst = 1;
    tick("R1"); tick("R1");
    expect_addr("R1", 0);
    rst = 0;

    // R2 + R7: controller strobe, linear from low bits 1 -> 1,2,3,0
    ads_ctrl = 1; mode = 0; addr_in = 18'h12341;
    tick("R2"); ads_ctrl = 0; expect_addr("R2", 'h12341);
    adv = 1;
    tick("R7"); expect_addr("R7", 'h12342);
    tick("R7"); expect_addr("R7", 'h12343);
    tick("R7"); expect_addr("R7", 'h12340);
    // R10 wrap back to start
    tick("R10"); expect_addr("R10", 'h12341);
    adv = 0;
    // R5 hold without advance
    tick("R5"); tick("R5"); expect_addr("R5", 'h12341);

    // R3 processor strobe + R6 interleaved from 1 -> 1,0,3,2
    ads_proc = 1; mode = 1; addr_in = 18'h2abc5;
    tick("R3"); ads_proc = 0; expect_addr("R3", 'h2abc5);
    adv = 1;
    tick("R6"); expect_addr("R6", 'h2abc4);
    mode = 0; // R11: mode change mid-burst ignored
    tick("R11"); expect_addr("R11", 'h2abc7);
    tick("R6"); expect_addr("R6", 'h2abc6);
    tick("R10"); expect_addr("R10", 'h2abc5);
    adv = 0;

    // R3: processor strobe ignored with ce_pri low
    ads_proc = 1; ce_pri = 0; addr_in = 18'h00003;
    tick("R3"); tick("R3"); expect_addr("R3", 'h2abc5);
    ads_proc = 0; ce_pri = 1;

    // R9: strobe mid-burst beats advance
    adv = 1; tick("R5");
    ads_ctrl = 1; mode = 0; addr_in = 18'h0fff2;
    tick("R9"); ads_ctrl = 0; expect_addr("R9", 'h0fff2);
    tick("R8"); expect_addr("R8", 'h0fff3);
    tick("R8"); expect_addr("R8", 'h0fff0);
    adv = 0;

    // R4: controller strobe with an expansion enable low ends burst
    ads_ctrl = 1; ce_aux2 = 0; addr_in = 18'h11111;
    tick("R4"); expect_addr("R4", 'h0fff0);
    ads_ctrl = 0; ce_aux2 = 1;
    // R5: advance with no active burst is ignored
    adv = 1; tick("R5"); tick("R5"); expect_addr("R5", 'h0fff0);
    adv = 0;
    // R4: processor strobe with ce_aux1 low
    ads_ctrl = 1; mode = 1; addr_in = 18'h3fffe; tick("R2"); ads_ctrl = 0;
    ads_proc = 1; ce_aux1 = 0; tick("R4"); ads_proc = 0; ce_aux1 = 1;

    // Sweep all start offsets in both orders
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        ads_ctrl = 1; mode = m[0]; addr_in = AW'(32'h20000 + 32'h40 + s);
        tick(m == 1 ? "R6" : "R7"); ads_ctrl = 0;
        for (int b = 0; b < 5; b++) begin
          adv = b[0] | b[1];
          tick(m == 1 ? "R6" : "R7");
        end
        adv = 0;
      end
    end

    rst = 1; tick("R1"); rst = 0;
    expect_addr("R1", 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule